// File: doc/BRIEF.md
# Split-line instruction cache

A read-only, four-way set-associative instruction cache holding 16 KB in 32-byte lines (128 sets). Every fetch returns 16 instruction bytes and the 5 predecode bits stored with each byte in the same clock as the request. A fetch at line offset 0, 8 or 16 reads within one line. A fetch at offset 24 is split: it reads the upper 8 bytes of the addressed line and the lower 8 bytes of the next sequential line. The split works whatever the parity of the first set index, and it also works across the last set, where the tag carries.

When a fetch misses, the block reports the address of the first line that is missing. The external logic then fetches that line and delivers it through the fill port as four 8-byte beats. The beat holding the requested chunk comes first and the others follow in wrap-around order. Each beat carries its predecode bits with it. The victim way of each set is picked by a round-robin pointer.

Lines have only two states, valid and invalid. A write in the core that hits a cached line is reported on the invalidate port, and the cache drops that line.

Top module: `split_icache`

## Requirements
- R1: After reset no line is valid, so every fetch misses (fetch_hit = 0).
- R2: A fetch at offset 0, 8 or 16 (fetch_addr[4:3] = 0, 1 or 2) that hits returns, in the same cycle, byte i of the 16 from address fetch_addr+i on fetch_bytes[8i+7:8i]. Its predecode bits appear on fetch_pdec[5i+4:5i]. fetch_addr[2:0] is ignored.
- R3: A fetch at offset 24 (fetch_addr[4:3] = 3) returns the upper 8 bytes of its line followed by the lower 8 bytes of the line 32 bytes above, and hits only if both lines are resident. This holds at even and odd set indices, and from set 127 to set 0 with the tag incremented.
- R4: When fetch_valid is 1 and fetch_hit is 0, fetch_miss_addr equals the 32-byte-aligned address of the first line that is not resident. That is the addressed line when it misses, otherwise the next line.
- R5: A fill beat writes 8 bytes and 40 predecode bits into chunk fill_addr[4:3] of the line addressed by fill_addr. Beats may start at any chunk and wrap around. The line becomes valid only at the beat marked fill_last.
- R6: The first beat of a fill evicts whatever line the victim way held, so that line misses from then on.
- R7: Each set has a round-robin victim pointer that advances by one when a fill completes. A fifth distinct line filled into a full set replaces the first one.
- R8: An invalidate clears the resident line whose tag and set match inv_addr. Other lines are unaffected, and an invalidate of a non-resident line changes nothing.
- R9: An invalidate of the line whose final fill beat arrives in the same cycle leaves that line invalid.
- R10: fetch_hit is 0 whenever fetch_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | 32 | Fetch byte address, 8-byte aligned |
| fetch_hit | output | 1 | All requested bytes are resident |
| fetch_bytes | output | 128 | 16 instruction bytes, lowest address in the low byte |
| fetch_pdec | output | 80 | 5 predecode bits per returned byte |
| fetch_miss_addr | output | 32 | Address of the first missing line |
| fill_valid | input | 1 | Fill beat present |
| fill_addr | input | 32 | Line address of the fill; bits [4:3] select the chunk |
| fill_data | input | 64 | 8 bytes of the chunk |
| fill_pdec | input | 40 | Predecode bits of the chunk |
| fill_last | input | 1 | Final beat of the line |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | 32 | Address inside the line to invalidate |

## Verification
Fetch results come from a combinational path. The bench therefore drives each fetch on a falling edge and compares the outputs 1 ns later, inside the same cycle. Fill beats and invalidates change state on the next rising edge. The bench drives them on a falling edge, withdraws them on the following falling edge, and makes any fetch that depends on them only after that. Every check therefore sees state that has settled. A mid-fill fetch is placed between two beats, after the first beat's edge has passed.

// File: rtl/split_icache.sv
module split_icache #(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 7,
  parameter int WAY_W  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [31:0]   fetch_addr,
  output logic          fetch_hit,
  output logic [127:0]  fetch_bytes,
  output logic [79:0]   fetch_pdec,
  output logic [31:0]   fetch_miss_addr,
  input  logic          fill_valid,
  input  logic [31:0]   fill_addr,
  input  logic [63:0]   fill_data,
  input  logic [39:0]   fill_pdec,
  input  logic          fill_last,
  input  logic          inv_valid,
  input  logic [31:0]   inv_addr
);
  localparam int LN_W  = ADDR_W - 5;
  localparam int TAG_W = LN_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 1 << WAY_W;
  localparam int ENT   = SETS * WAYS;
  localparam int IDX_W = SET_W + WAY_W;
  localparam int CH_W  = 64 + 40;

  logic [TAG_W-1:0] tag_q [ENT];
  logic [ENT-1:0]   vld_q;
  logic [WAY_W-1:0] rr_q  [SETS];
  logic [CH_W-1:0]  mem_q [ENT*4];

  function automatic logic [WAY_W:0] lookup(input logic [SET_W-1:0] s, input logic [TAG_W-1:0] t);
    logic [WAY_W:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[{s, WAY_W'(w)}] && tag_q[{s, WAY_W'(w)}] == t) r = {1'b1, WAY_W'(w)};
    return r;
  endfunction

  wire [LN_W-1:0]  ln_a  = fetch_addr[ADDR_W-1:5];
  wire [LN_W-1:0]  ln_b  = ln_a + 1'b1;
  wire [SET_W-1:0] set_a = ln_a[SET_W-1:0];
  wire [SET_W-1:0] set_b = ln_b[SET_W-1:0];
  wire [1:0]       off   = fetch_addr[4:3];
  wire             split = &off;

  wire [SET_W-1:0] fset = fill_addr[SET_W+4:5];
  wire [SET_W-1:0] iset = inv_addr[SET_W+4:5];

  logic             hit_a, hit_b, inv_hit;
  logic [WAY_W-1:0] way_a, way_b, inv_way;

  always_comb begin
    {hit_a, way_a}     = lookup(set_a, ln_a[LN_W-1:SET_W]);
    {hit_b, way_b}     = lookup(set_b, ln_b[LN_W-1:SET_W]);
    {inv_hit, inv_way} = lookup(iset, inv_addr[ADDR_W-1:SET_W+5]);
  end

  wire [WAY_W-1:0] victim   = rr_q[fset];
  wire [IDX_W-1:0] fill_idx = {fset, victim};
  wire [IDX_W-1:0] inv_idx  = {iset, inv_way};
  wire inv_same = inv_valid && fill_valid && fill_last &&
                  inv_addr[ADDR_W-1:5] == fill_addr[ADDR_W-1:5];

  wire [CH_W-1:0] c0 = mem_q[{set_a, way_a, off}];
  wire [CH_W-1:0] c1 = split ? mem_q[{set_b, way_b, 2'd0}] : mem_q[{set_a, way_a, off + 2'd1}];

  assign fetch_hit       = fetch_valid && hit_a && (!split || hit_b);
  assign fetch_bytes     = {c1[63:0], c0[63:0]};
  assign fetch_pdec      = {c1[CH_W-1:64], c0[CH_W-1:64]};
  assign fetch_miss_addr = {hit_a ? ln_b : ln_a, 5'd0};

  wire unused_ok = ^{fetch_addr[2:0], fill_addr[2:0], inv_addr[4:0]};

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      mem_q[{fill_idx, fill_addr[4:3]}] <= {fill_pdec, fill_data};
      if (fill_last) tag_q[fill_idx] <= fill_addr[ADDR_W-1:SET_W+5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      if (fill_valid) begin
        vld_q[fill_idx] <= fill_last;
        if (fill_last) rr_q[fset] <= victim + 1'b1;
      end
      if (inv_valid && inv_hit) vld_q[inv_idx] <= 1'b0;
      if (inv_same) vld_q[fill_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/split_icache_chk.sv
module split_icache_chk #(
  parameter int IDX_W = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fetch_valid,
  input logic                fetch_hit,
  input logic                fill_valid,
  input logic                fill_last,
  input logic                inv_valid,
  input logic                inv_hit,
  input logic                inv_same,
  input logic [IDX_W-1:0]    fill_idx,
  input logic [IDX_W-1:0]    inv_idx,
  input logic [(1<<IDX_W)-1:0] vld
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> vld == '0);

  // R10
  idle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !fetch_hit);

  // R5
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_last && !inv_same && !(inv_valid && inv_hit && inv_idx == fill_idx)
    |=> vld[$past(fill_idx)]);

  // R6
  partial_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_last |=> !vld[$past(fill_idx)]);

  // R8
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && inv_hit |=> !vld[$past(inv_idx)]);

  // R9
  inv_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_same |=> !vld[$past(fill_idx)]);
endmodule

bind split_icache split_icache_chk #(.IDX_W(SET_W + WAY_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_hit(fetch_hit),
  .fill_valid(fill_valid), .fill_last(fill_last), .inv_valid(inv_valid),
  .inv_hit(inv_hit), .inv_same(inv_same), .fill_idx(fill_idx),
  .inv_idx(inv_idx), .vld(vld_q)
);

// File: tb/test_split_icache.sv
`timescale 1ns/1ps
module test_split_icache;
  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, fill_valid = 0, fill_last = 0, inv_valid = 0;
  logic [31:0] fetch_addr = 0, fill_addr = 0, inv_addr = 0, fetch_miss_addr;
  logic [63:0] fill_data = 0;
  logic [39:0] fill_pdec = 0;
  logic fetch_hit;
  logic [127:0] fetch_bytes;
  logic [79:0] fetch_pdec;

  split_icache i_split_icache (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [19:0] tm [128][4];
  bit          vm [128][4];
  int          rrm [128];

  function automatic [31:0] mk(input int t, input int s, input int o);
    return {t[19:0], s[6:0], o[4:0]};
  endfunction
  function automatic [7:0] cbyte(input [31:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic [4:0] cpd(input [31:0] a);
    return a[4:0] ^ a[9:5] ^ a[14:10] ^ a[19:15] ^ 5'h0B;
  endfunction
  function automatic bit m_hit(input [31:0] a);
    for (int w = 0; w < 4; w++) if (vm[a[11:5]][w] && tm[a[11:5]][w] == a[31:12]) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string r, input [127:0] act, input [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic check_fetch(input [31:0] a, input string r);
    logic [31:0] la, lb;
    bit eh;
    logic [127:0] eb;
    logic [79:0] ep;
    @(negedge clk);
    fetch_valid = 1; fetch_addr = a;
    #1;
    la = {a[31:5], 5'd0}; lb = la + 32;
    eh = m_hit(la) && (a[4:3] != 2'd3 || m_hit(lb));
    chk(fetch_hit == eh, {r, " hit"}, 128'(fetch_hit), 128'(eh));
    if (eh) begin
      for (int i = 0; i < 16; i++) begin
        eb[8*i +: 8] = cbyte({a[31:3], 3'd0} + i);
        ep[5*i +: 5] = cpd({a[31:3], 3'd0} + i);
      end
      chk(fetch_bytes == eb, {r, " bytes"}, fetch_bytes, eb);
      chk(fetch_pdec == ep, {r, " pdec"}, 128'(fetch_pdec), 128'(ep));
    end else begin
      chk(fetch_miss_addr == (m_hit(la) ? lb : la), {r, " miss_addr"},
          128'(fetch_miss_addr), 128'(m_hit(la) ? lb : la));
    end
    fetch_valid = 0;
  endtask

  task automatic model_inv(input [31:0] a);
    for (int w = 0; w < 4; w++) if (tm[a[11:5]][w] == a[31:12]) vm[a[11:5]][w] = 0;
  endtask

  task automatic fill_beat(input [31:0] la, input [1:0] ch, input bit last, input bit inv);
    int s, w;
    @(negedge clk);
    fill_valid = 1; fill_last = last;
    fill_addr = {la[31:5], ch, 3'd0};
    for (int j = 0; j < 8; j++) begin
      fill_data[8*j +: 8] = cbyte(fill_addr + j);
      fill_pdec[5*j +: 5] = cpd(fill_addr + j);
    end
    inv_valid = inv; inv_addr = la;
    s = la[11:5]; w = rrm[s];
    vm[s][w] = 0;
    if (last) begin
      tm[s][w] = la[31:12]; vm[s][w] = 1; rrm[s] = (w + 1) % 4;
    end
    if (inv) model_inv(la);
    @(negedge clk);
    fill_valid = 0; fill_last = 0; inv_valid = 0;
  endtask

  task automatic do_fill(input [31:0] la, input [1:0] crit, input bit inv_last);
    for (int k = 0; k < 4; k++) fill_beat(la, 2'(crit + k), k == 3, inv_last && k == 3);
  endtask

  task automatic do_inv(input [31:0] a);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    model_inv(a);
    @(negedge clk);
    inv_valid = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned sd;
    int sets [5] = '{0, 1, 2, 126, 127};
    sd = $urandom(32'd4242);
    for (int s = 0; s < 128; s++) begin
      rrm[s] = 0;
      for (int w = 0; w < 4; w++) begin vm[s][w] = 0; tm[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    check_fetch(mk(1, 10, 0), "R1");
    check_fetch(mk(0, 0, 24), "R1");
    // R5 partial then complete, critical chunk 2
    fill_beat(mk(1, 10, 0), 2'd2, 0, 0);
    check_fetch(mk(1, 10, 16), "R5 partial");
    fill_beat(mk(1, 10, 0), 2'd3, 0, 0);
    fill_beat(mk(1, 10, 0), 2'd0, 0, 0);
    fill_beat(mk(1, 10, 0), 2'd1, 1, 0);
    check_fetch(mk(1, 10, 0), "R2 R5");
    check_fetch(mk(1, 10, 8), "R2");
    check_fetch(mk(1, 10, 21), "R2");
    // R3 R4 split at even index
    check_fetch(mk(1, 10, 24), "R3 R4");
    do_fill(mk(1, 11, 0), 2'd3, 0);
    check_fetch(mk(1, 10, 24), "R3 even");
    check_fetch(mk(1, 11, 24), "R4 odd");
    do_fill(mk(1, 12, 0), 2'd1, 0);
    check_fetch(mk(1, 11, 24), "R3 odd");
    do_fill(mk(1, 127, 0), 2'd0, 0);
    check_fetch(mk(1, 127, 24), "R4 wrap");
    do_fill(mk(2, 0, 0), 2'd2, 0);
    check_fetch(mk(1, 127, 24), "R3 wrap");
    check_fetch(mk(3, 10, 24), "R4 first");
    // R7 round robin in set 40
    for (int t = 1; t <= 4; t++) do_fill(mk(t, 40, 0), 2'(t), 0);
    for (int t = 1; t <= 4; t++) check_fetch(mk(t, 40, 8), "R7 fill");
    do_fill(mk(5, 40, 0), 2'd0, 0);
    check_fetch(mk(1, 40, 0), "R7 evict");
    check_fetch(mk(2, 40, 0), "R7 keep");
    do_fill(mk(6, 40, 0), 2'd0, 0);
    check_fetch(mk(2, 40, 0), "R7 evict2");
    // R6 victim evicted by the first beat (victim holds tag 3)
    fill_beat(mk(7, 40, 0), 2'd1, 0, 0);
    check_fetch(mk(3, 40, 0), "R6");
    check_fetch(mk(4, 40, 0), "R6 other");
    fill_beat(mk(7, 40, 0), 2'd2, 0, 0);
    fill_beat(mk(7, 40, 0), 2'd3, 0, 0);
    fill_beat(mk(7, 40, 0), 2'd0, 1, 0);
    check_fetch(mk(7, 40, 16), "R5 R6");
    // R8
    do_inv(mk(5, 40, 8));
    check_fetch(mk(5, 40, 0), "R8 cleared");
    check_fetch(mk(4, 40, 0), "R8 other");
    do_inv(mk(9, 40, 0));
    check_fetch(mk(4, 40, 0), "R8 absent");
    check_fetch(mk(6, 40, 0), "R8 absent");
    check_fetch(mk(7, 40, 0), "R8 absent");
    // R9
    do_fill(mk(1, 50, 0), 2'd1, 1);
    check_fetch(mk(1, 50, 0), "R9");
    // R10
    @(negedge clk);
    fetch_valid = 0; fetch_addr = mk(1, 10, 0);
    #1;
    chk(fetch_hit == 0, "R10", 128'(fetch_hit), 128'(0));
    // random
    for (int it = 0; it < 600; it++) begin
      logic [31:0] a;
      int op;
      a = mk($urandom_range(0, 5), sets[$urandom_range(0, 4)], 8 * $urandom_range(0, 3));
      op = $urandom_range(0, 9);
      if (op < 2) do_inv(a);
      else begin
        check_fetch(a, "R2 R3 R4 random");
        if (!m_hit({a[31:5], 5'd0})) do_fill({a[31:5], 5'd0}, 2'($urandom_range(0, 3)), 0);
        else if (a[4:3] == 2'd3 && !m_hit({a[31:5], 5'd0} + 32))
          do_fill({a[31:5], 5'd0} + 32, 2'($urandom_range(0, 3)), 0);
        check_fetch(a, "R5 R7 random");
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule